// File: doc/BRIEF.md
# Skewed-Clock ADC Sample Receiver

This block paces a sampling converter on a fixed frame of system clock cycles and collects each returned sample in a second clock domain. That second domain runs on the clock the converter sends back alongside its data. This returned clock has the system frequency but arrives with an unknown phase delay. A frame counter in the system domain marks each frame boundary by inverting a level flag. Because a level rather than a pulse crosses the boundary, the receive side can detect it at any phase offset.

The receive domain double-registers the flag and compares it with a private copy. A difference means a new frame has begun. On that edge the block moves the sample it has been buffering to the output register, steps a sample index and raises a one-cycle done flag. The done flag returns to the system clock through a two-flop synchronizer and an edge detector, which give a single-cycle valid pulse. After reset, the system side holds a request that makes the receive side realign its flag copy and clear its index. The request is kept until the receive side acknowledges it. Data entry is modelled as a parallel load of a data word on every returned-clock edge.

Top module: `adc_frame_rx`

## Requirements
- R1: While `rst_n` is low, `sample_vld` is 0, `sample_q` is 0 and `sample_idx` is 0.
- R2: Once running, consecutive `sample_vld` pulses are exactly FRAME_LEN (default 21) system clock cycles apart.
- R3: `sample_vld` is never high for two system cycles in a row.
- R4: Each captured `sample_q` is the `rx_din` word loaded on a returned-clock edge. Two consecutive samples come from edges exactly FRAME_LEN returned-clock cycles apart.
- R5: `sample_idx` is 1 at the first valid pulse after reset. It then rises by one with each pulse, modulo 2^IDX_W (default 256).
- R6: `sample_q` and `sample_idx` stay unchanged for at least 15 system cycles after each valid pulse.
- R7: The first valid pulse after `rst_n` rises comes no earlier than FRAME_LEN and no later than FRAME_LEN+24 system cycles after the release. No stale sample appears before it.
- R8: R2 to R7 hold for any phase delay of `rx_clk` relative to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rx_clk | input | 1 | Returned, phase-delayed copy of the sampling clock |
| rx_din | input | DW | Sample word presented in the `rx_clk` domain |
| sample_q | output | DW | Last captured sample, stable for the frame after its valid pulse |
| sample_idx | output | IDX_W | Count of samples captured since reset |
| sample_vld | output | 1 | One-cycle pulse in the `clk` domain announcing a new sample |

## Verification
The bench uses the defaults: a 21-cycle frame, 16-bit data and an 8-bit index. A first long run of 300 frames carries the index through its wrap from 255 to 0. Further runs reset the block mid-stream and shift the returned clock by random fractions of a period, plus a half-period case. This covers the flag and done crossings at many phase relations. Data words are an invertible product of the returned-clock edge number, so each captured word shows exactly which edge loaded it.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  localparam int unsigned SYNC_MIN_STAGES = 2;

  function automatic int unsigned cnt_width(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] rst_sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_sh <= '0;
    else         rst_sh <= {rst_sh[STAGES-2:0], 1'b1};
  end

  assign srst_n = rst_sh[STAGES-1];
endmodule

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sync_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_sh <= {STAGES{RST_VAL}};
    else        sync_sh <= {sync_sh[STAGES-2:0], d};
  end

  assign q = sync_sh[STAGES-1];
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_rx_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s,
  output logic frame_flag,
  output logic rx_req
);
  localparam int unsigned CW = cnt_width(FRAME_LEN);
  localparam logic [CW-1:0] LAST = CW'(FRAME_LEN - 1);

  logic [CW-1:0] cnt, cnt_nxt;
  logic          wrap;
  logic          flag_nxt, req_nxt;

  always_comb begin
    wrap     = (cnt == LAST);
    cnt_nxt  = wrap ? '0 : cnt + CW'(1);
    flag_nxt = frame_flag ^ wrap;
    req_nxt  = rx_req & ~ack_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      frame_flag <= 1'b0;
      rx_req     <= 1'b1;
    end else begin
      cnt        <= cnt_nxt;
      frame_flag <= flag_nxt;
      rx_req     <= req_nxt;
    end
  end

  // R2
  frame_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R2
  flag_flip_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_flag != $past(frame_flag)) |-> ($past(cnt) == LAST));

  // R7
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_req) |-> $past(ack_s));
endmodule

// File: rtl/adc_rx_capture.sv
module adc_rx_capture #(
  parameter int unsigned DW    = 16,
  parameter int unsigned IDX_W = 8
) (
  input  logic             rx_clk,
  input  logic             rx_rst_n,
  input  logic             flag_s,
  input  logic             req_s,
  input  logic [DW-1:0]    din,
  output logic             ack,
  output logic             done,
  output logic [DW-1:0]    smp,
  output logic [IDX_W-1:0] idx
);
  logic          flag_copy, copy_nxt;
  logic [DW-1:0] buf_q;
  logic          edge_seen;
  logic          cap_en, buf_en;
  logic [IDX_W-1:0] idx_nxt;

  always_comb begin
    edge_seen = (flag_s != flag_copy);
    cap_en    = ~req_s & edge_seen;
    buf_en    = ~req_s & ~edge_seen;
    copy_nxt  = (req_s | edge_seen) ? flag_s : flag_copy;
    if (req_s)       idx_nxt = '0;
    else if (cap_en) idx_nxt = idx + IDX_W'(1);
    else             idx_nxt = idx;
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      ack       <= 1'b0;
      done      <= 1'b0;
      flag_copy <= 1'b0;
      idx       <= '0;
    end else begin
      ack       <= req_s;
      done      <= cap_en;
      flag_copy <= copy_nxt;
      idx       <= idx_nxt;
    end
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n)   buf_q <= '0;
    else if (buf_en) buf_q <= din;
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n)   smp <= '0;
    else if (cap_en) smp <= buf_q;
  end

  // R3
  done_single_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    done |=> !done);

  // R5
  idx_step_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (idx != $past(idx)) |-> ($past(req_s) || (done && (idx == $past(idx) + IDX_W'(1)))));

  // R6
  smp_hold_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (smp != $past(smp)) |-> done);
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx
  import adc_rx_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned FRAME_LEN   = 21,
  parameter int unsigned IDX_W       = 8,
  parameter int unsigned SYNC_STAGES = SYNC_MIN_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_clk,
  input  logic [DW-1:0]    rx_din,
  output logic [DW-1:0]    sample_q,
  output logic [IDX_W-1:0] sample_idx,
  output logic             sample_vld
);
  logic sys_rst_n, rx_rst_n;
  logic frame_flag, rx_req;
  logic flag_s, req_s, ack, ack_s;
  logic done, done_s, done_d;

  adc_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(sys_rst_n));

  adc_rst_sync #(.STAGES(SYNC_STAGES)) u_rx_rst (
    .clk(rx_clk), .arst_n(rst_n), .srst_n(rx_rst_n));

  adc_frame_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk(clk), .rst_n(sys_rst_n), .ack_s(ack_s),
    .frame_flag(frame_flag), .rx_req(rx_req));

  adc_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_flag_sync (
    .clk(rx_clk), .rst_n(rx_rst_n), .d(frame_flag), .q(flag_s));

  adc_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk(rx_clk), .rst_n(rx_rst_n), .d(rx_req), .q(req_s));

  adc_rx_capture #(.DW(DW), .IDX_W(IDX_W)) u_cap (
    .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .flag_s(flag_s), .req_s(req_s),
    .din(rx_din), .ack(ack), .done(done), .smp(sample_q), .idx(sample_idx));

  adc_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk(clk), .rst_n(sys_rst_n), .d(ack), .q(ack_s));

  adc_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
    .clk(clk), .rst_n(sys_rst_n), .d(done), .q(done_s));

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) done_d <= 1'b0;
    else            done_d <= done_s;
  end

  assign sample_vld = done_s & ~done_d;

  // R3
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    sample_vld |=> !sample_vld);
endmodule

// File: tb/adc_frame_rx_bench.sv
`timescale 1ns/1ps
module adc_frame_rx_bench;
  localparam int DW = 16;
  localparam int FL = 21;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rx_clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] rx_din = '0;
  logic [DW-1:0] sample_q;
  logic [IW-1:0] sample_idx;
  logic sample_vld;

  int n_chk = 0;
  int n_fail = 0;
  int skew_add = 0;
  int rx_n = 0;
  int unsigned mult;
  int unsigned inv;

  adc_frame_rx #(.DW(DW), .FRAME_LEN(FL), .IDX_W(IW)) u_adc_frame_rx (
    .clk(clk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_din(rx_din),
    .sample_q(sample_q), .sample_idx(sample_idx), .sample_vld(sample_vld));

  always #4 clk = ~clk;

  initial begin
    forever begin
      if (skew_add > 0) begin
        #(real'(skew_add) / 1000.0);
        skew_add = 0;
      end
      #4 rx_clk = ~rx_clk;
    end
  end

  always @(negedge rx_clk) begin
    rx_n   <= rx_n + 1;
    rx_din <= DW'(rx_n * mult);
  end

  function automatic logic [DW-1:0] decode(logic [DW-1:0] s);
    return DW'(int'(s) * inv);
  endfunction

  function automatic logic [IW-1:0] next_idx(logic [IW-1:0] i);
    return IW'(i + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_phase(int frames, int skew_ps);
    int cyc = 0;
    int last_cyc = 0;
    bit seen = 0;
    bit prev_vld = 0;
    logic [DW-1:0] last_q = '0;
    logic [IW-1:0] last_idx = '0;
    @(negedge clk);
    rst_n = 1'b0;
    skew_add = skew_ps;
    repeat (6) @(negedge clk);
    // R1 reset state
    check(sample_vld == 1'b0, "R1 vld", int'(sample_vld), 0);
    check(sample_q == '0, "R1 sample", int'(sample_q), 0);
    check(sample_idx == '0, "R1 idx", int'(sample_idx), 0);
    rst_n = 1'b1;
    for (int k = 0; k < frames * FL + 40; k++) begin
      @(negedge clk);
      cyc++;
      if (sample_vld) begin
        // R3 single-cycle pulse
        check(!prev_vld, "R3", 1, 0);
        if (!seen) begin
          // R7 first pulse window, R5 first index
          check(cyc >= FL && cyc <= FL + 24, "R7", cyc, FL);
          check(sample_idx == IW'(1), "R5 first", int'(sample_idx), 1);
        end else begin
          // R2 period (R8: under current skew)
          check(cyc - last_cyc == FL, "R2", cyc - last_cyc, FL);
          check(sample_idx == next_idx(last_idx), "R5",
                int'(sample_idx), int'(next_idx(last_idx)));
          // R4 spacing of the loading edges
          check(DW'(decode(sample_q) - decode(last_q)) == DW'(FL), "R4",
                int'(DW'(decode(sample_q) - decode(last_q))), FL);
        end
        seen = 1;
        last_cyc = cyc;
        last_q = sample_q;
        last_idx = sample_idx;
      end else if (seen && (cyc - last_cyc) <= 15) begin
        // R6 hold after pulse
        check(sample_q == last_q && sample_idx == last_idx, "R6",
              int'(sample_q), int'(last_q));
      end
      prev_vld = sample_vld;
    end
    check(seen, "R7 any pulse", int'(seen), 1);
  endtask

  initial begin
    mult = $urandom(32'd4242) | 32'd1;
    inv = mult;
    for (int i = 0; i < 5; i++) inv = inv * (32'd2 - mult * inv);
    run_phase(300, 0);
    run_phase(30, 4000);
    run_phase(30, int'($urandom_range(1, 7999)));
    run_phase(30, int'($urandom_range(1, 7999)));
    run_phase(20, int'($urandom_range(1, 7999)));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule